// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This unit keeps a signed 64-bit accumulator, stored as a high word and a low word, and adds a signed product into it whenever an operation is strobed. Two product forms exist. The long form multiplies two full 32-bit signed operands. The word form multiplies only the signed low 16 bits of each operand.

A saturation-mode input changes how the sum is written back, and each form clamps in its own way. The long form confines the high word to a range of about 48 bits. The word form clamps the result to the 32-bit signed limits and leaves the value 1 in the high word as an overflow marker.

Software-visible state is limited to the two accumulator words. Each word can be loaded directly, and a clear input zeroes both words. The result and a one-cycle done pulse appear on the clock edge that follows the strobe.

Top module: `sat_mac_unit`

## Requirements
- R1: After reset both accumulator words read zero and `mac_done` is low.
- R2: A long operation (`mac_form`=0) with `sat_mode`=0 adds the full signed 64-bit product of `opnd_a` and `opnd_b` to {`acc_hi`,`acc_lo`}, wrapping modulo 2^64.
- R3: A word operation (`mac_form`=1) multiplies only bits 15:0 of each operand, taken as signed. With `sat_mode`=0 it adds that product to the 64-bit accumulator, and bits 31:16 of the operands have no effect.
- R4: In a long operation with `sat_mode`=1, `acc_lo` receives the low half of the 64-bit sum. If the sum is negative, `acc_hi` is the high half of the sum with bits 31:16 forced to one. Otherwise `acc_hi` is the high half of the sum with every bit above bit 14 cleared.
- R5: In a word operation with `sat_mode`=1, a sum above 2^31-1 gives `acc_lo`=0x7FFFFFFF and `acc_hi`=1. A sum below -2^31 gives `acc_lo`=0x80000000 and `acc_hi`=1.
- R6: In a word operation with `sat_mode`=1, a sum inside the range [-2^31, 2^31-1] is stored unchanged in both words.
- R7: `acc_clr` zeroes both words at the next edge and takes priority over any load or operation in the same cycle.
- R8: `ld_hi` or `ld_lo` writes `ld_data` into the selected word at the next edge, and the word that is not selected keeps its value. Both may be asserted together.
- R9: The accumulator result and a `mac_done` pulse appear at the edge after `mac_go`. The pulse lasts one cycle. While no strobe, load or clear is present, both words hold their values.
- R10: When `mac_go` coincides with `acc_clr`, `ld_hi` or `ld_lo`, the operation is dropped. No product is added and `mac_done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mac_go | input | 1 | Operation strobe |
| mac_form | input | 1 | 0 = long 32x32 form, 1 = word 16x16 form |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| sat_mode | input | 1 | Saturating write-back when high |
| acc_clr | input | 1 | Zero both accumulator words |
| ld_hi | input | 1 | Load `ld_data` into the high word |
| ld_lo | input | 1 | Load `ld_data` into the low word |
| ld_data | input | 32 | Data for direct loads |
| acc_hi | output | 32 | Accumulator bits 63:32 |
| acc_lo | output | 32 | Accumulator bits 31:0 |
| mac_done | output | 1 | One-cycle pulse after an accepted operation |

## Verification
Two requests can reach the accumulator in the same cycle: an operation strobe, and either a clear or a direct word load. The bench raises `mac_go` in the same cycle as `acc_clr`, and again in the same cycle as `ld_hi`. In each case it checks that both words hold exactly the cleared or loaded values and that `mac_done` stays low, which shows the product was not added. It then issues a normal strobe and checks that accumulation resumes from those values.

// File: rtl/smac_pkg.sv
package smac_pkg;
  typedef enum logic {
    FORM_LONG = 1'b0,
    FORM_WORD = 1'b1
  } mac_form_e;

  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_MAC   = 2'd3
  } acc_act_e;
endpackage

// File: rtl/smac_product.sv
module smac_product #(
  parameter int DATA_W  = 32,
  parameter int SHORT_W = 16
) (
  input  smac_pkg::mac_form_e      form,
  input  logic [DATA_W-1:0]        src_a,
  input  logic [DATA_W-1:0]        src_b,
  output logic [2*DATA_W-1:0]      product
);
  localparam int ACC_W = 2 * DATA_W;

  function automatic logic [ACC_W-1:0] sext_full(input logic [DATA_W-1:0] v);
    return {{DATA_W{v[DATA_W-1]}}, v};
  endfunction

  function automatic logic [ACC_W-1:0] sext_short(input logic [DATA_W-1:0] v);
    return {{(ACC_W-SHORT_W){v[SHORT_W-1]}}, v[SHORT_W-1:0]};
  endfunction

  // Operands sign-extended to the full accumulator width, so the low
  // ACC_W bits of the product are the exact signed result.
  function automatic logic [ACC_W-1:0] mul_wide(input logic [ACC_W-1:0] x,
                                                input logic [ACC_W-1:0] y);
    return x * y;
  endfunction

  logic [ACC_W-1:0] long_p;
  logic [ACC_W-1:0] word_p;

  always_comb begin
    long_p = mul_wide(sext_full(src_a), sext_full(src_b));
    word_p = mul_wide(sext_short(src_a), sext_short(src_b));
  end

  assign product = (form == smac_pkg::FORM_WORD) ? word_p : long_p;
endmodule

// File: rtl/smac_saturate.sv
module smac_saturate #(
  parameter int DATA_W = 32
) (
  input  smac_pkg::mac_form_e  form,
  input  logic                 sat_on,
  input  logic [DATA_W-1:0]    cur_hi,
  input  logic [DATA_W-1:0]    cur_lo,
  input  logic [2*DATA_W-1:0]  product,
  output logic [DATA_W-1:0]    next_hi,
  output logic [DATA_W-1:0]    next_lo,
  output logic                 word_over,
  output logic                 word_under,
  output logic                 long_neg
);
  localparam int ACC_W  = 2 * DATA_W;
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] LONG_SET  = {{HALF_W{1'b1}}, {(DATA_W-HALF_W){1'b0}}};
  localparam logic [DATA_W-1:0] LONG_KEEP = {{(DATA_W-HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
  localparam logic [ACC_W-1:0]  WORD_MIN  = {{(DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic [ACC_W-1:0]  WORD_MAX  = {{(DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] LO_MIN    = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] LO_MAX    = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] HI_MARK   = {{(DATA_W-1){1'b0}}, 1'b1};

  function automatic logic [DATA_W-1:0] clamp_long_hi(input logic [DATA_W-1:0] hi,
                                                      input logic neg);
    return neg ? (hi | LONG_SET) : (hi & LONG_KEEP);
  endfunction

  logic [ACC_W-1:0] sum;

  always_comb begin
    sum        = {cur_hi, cur_lo} + product;
    long_neg   = sum[ACC_W-1];
    word_over  = $signed(sum) > $signed(WORD_MAX);
    word_under = $signed(sum) < $signed(WORD_MIN);
    next_hi    = sum[ACC_W-1:DATA_W];
    next_lo    = sum[DATA_W-1:0];
    if (sat_on) begin
      if (form == smac_pkg::FORM_LONG) begin
        next_hi = clamp_long_hi(sum[ACC_W-1:DATA_W], long_neg);
      end else if (word_over) begin
        next_hi = HI_MARK;
        next_lo = LO_MAX;
      end else if (word_under) begin
        next_hi = HI_MARK;
        next_lo = LO_MIN;
      end
    end
  end
endmodule

// File: rtl/smac_acc_regs.sv
module smac_acc_regs #(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  smac_pkg::acc_act_e   act,
  input  logic                 wr_hi,
  input  logic                 wr_lo,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [DATA_W-1:0]    next_hi,
  input  logic [DATA_W-1:0]    next_lo,
  output logic [DATA_W-1:0]    hi_q,
  output logic [DATA_W-1:0]    lo_q,
  output logic                 done_q
);
  import smac_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (act == ACT_MAC);
      case (act)
        ACT_CLEAR: begin
          hi_q <= '0;
          lo_q <= '0;
        end
        ACT_LOAD: begin
          if (wr_hi) hi_q <= wr_data;
          if (wr_lo) lo_q <= wr_data;
        end
        ACT_MAC: begin
          hi_q <= next_hi;
          lo_q <= next_lo;
        end
        default: ;
      endcase
    end
  end

  // R7
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_CLEAR |=> (hi_q == '0) && (lo_q == '0));
  // R8
  a_r8_load_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_LOAD) && wr_hi |=> hi_q == $past(wr_data));
  // R8
  a_r8_keep_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_LOAD) && !wr_lo |=> $stable(lo_q));
  // R9
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_MAC |=> done_q);
  // R10
  a_r10_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    act != ACT_MAC |=> !done_q);
  // R9
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_IDLE |=> $stable(hi_q) && $stable(lo_q));
endmodule

// File: rtl/sat_mac_unit.sv
module sat_mac_unit #(
  parameter int DATA_W  = 32,
  parameter int SHORT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mac_go,
  input  logic              mac_form,
  input  logic [31:0]       opnd_a,
  input  logic [31:0]       opnd_b,
  input  logic              sat_mode,
  input  logic              acc_clr,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic [31:0]       ld_data,
  output logic [31:0]       acc_hi,
  output logic [31:0]       acc_lo,
  output logic              mac_done
);
  import smac_pkg::*;

  localparam int ACC_W  = 2 * DATA_W;
  localparam int HALF_W = DATA_W / 2;

  mac_form_e         form;
  acc_act_e          act;
  logic              load_req;
  logic              mac_fire;
  logic [ACC_W-1:0]  product;
  logic [DATA_W-1:0] next_hi;
  logic [DATA_W-1:0] next_lo;
  logic              word_over;
  logic              word_under;
  logic              long_neg;

  assign form     = mac_form_e'(mac_form);
  assign load_req = ld_hi | ld_lo;

  // Clear beats load, load beats an operation.
  always_comb begin
    if (acc_clr)       act = ACT_CLEAR;
    else if (load_req) act = ACT_LOAD;
    else if (mac_go)   act = ACT_MAC;
    else               act = ACT_IDLE;
  end
  assign mac_fire = (act == ACT_MAC);

  smac_product #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_product (
    .form    (form),
    .src_a   (opnd_a),
    .src_b   (opnd_b),
    .product (product)
  );

  smac_saturate #(.DATA_W(DATA_W)) u_saturate (
    .form       (form),
    .sat_on     (sat_mode),
    .cur_hi     (acc_hi),
    .cur_lo     (acc_lo),
    .product    (product),
    .next_hi    (next_hi),
    .next_lo    (next_lo),
    .word_over  (word_over),
    .word_under (word_under),
    .long_neg   (long_neg)
  );

  smac_acc_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (act),
    .wr_hi   (ld_hi),
    .wr_lo   (ld_lo),
    .wr_data (ld_data),
    .next_hi (next_hi),
    .next_lo (next_lo),
    .hi_q    (acc_hi),
    .lo_q    (acc_lo),
    .done_q  (mac_done)
  );

  // R4
  a_r4_long_neg_band: assert property (@(posedge clk) disable iff (!rst_n)
    mac_fire && sat_mode && (form == FORM_LONG) && long_neg
    |=> acc_hi[DATA_W-1:DATA_W-HALF_W] == {HALF_W{1'b1}});
  // R4
  a_r4_long_pos_band: assert property (@(posedge clk) disable iff (!rst_n)
    mac_fire && sat_mode && (form == FORM_LONG) && !long_neg
    |=> acc_hi[DATA_W-1:HALF_W-1] == '0);
  // R5
  a_r5_word_marker: assert property (@(posedge clk) disable iff (!rst_n)
    mac_fire && sat_mode && (form == FORM_WORD) && (word_over || word_under)
    |=> acc_hi == 1);
  // R6
  a_r6_word_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mac_fire && sat_mode && (form == FORM_WORD) && !word_over && !word_under
    |=> (acc_hi == '0) || (acc_hi == '1));
  // R5
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_over && word_under));
endmodule

// File: tb/test_sat_mac_unit.sv
`timescale 1ns/1ps
module test_sat_mac_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mac_go = 1'b0, mac_form = 1'b0, sat_mode = 1'b0;
  logic        acc_clr = 1'b0, ld_hi = 1'b0, ld_lo = 1'b0;
  logic [31:0] opnd_a = '0, opnd_b = '0, ld_data = '0;
  logic [31:0] acc_hi, acc_lo;
  logic        mac_done;
  int          n_chk = 0;
  int          n_err = 0;
  logic [31:0] m_hi = '0, m_lo = '0;

  always #2.5 clk = ~clk;

  sat_mac_unit i_sat_mac_unit (
    .clk(clk), .rst_n(rst_n), .mac_go(mac_go), .mac_form(mac_form),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .sat_mode(sat_mode),
    .acc_clr(acc_clr), .ld_hi(ld_hi), .ld_lo(ld_lo), .ld_data(ld_data),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .mac_done(mac_done)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // Independent reference built on 64-bit signed integers.
  task automatic model(input bit word, input bit sat, input logic [31:0] a, input logic [31:0] b);
    longint acc, p, s;
    acc = longint'({m_hi, m_lo});
    if (word) p = longint'(shortint'(a[15:0])) * longint'(shortint'(b[15:0]));
    else      p = longint'(int'(a)) * longint'(int'(b));
    s = acc + p;
    m_hi = s[63:32];
    m_lo = s[31:0];
    if (sat && !word) begin
      if (s < 0) m_hi = m_hi | 32'hFFFF_0000;
      else       m_hi = m_hi & 32'h0000_7FFF;
    end else if (sat && word) begin
      if (s > 64'sd2147483647) begin m_hi = 1; m_lo = 32'h7FFF_FFFF; end
      else if (s < -64'sd2147483648) begin m_hi = 1; m_lo = 32'h8000_0000; end
    end
  endtask

  task automatic set_acc(input logic [31:0] h, input logic [31:0] l);
    @(negedge clk); ld_hi = 1; ld_data = h;
    @(negedge clk); ld_hi = 0; ld_lo = 1; ld_data = l;
    @(negedge clk); ld_lo = 0;
    m_hi = h; m_lo = l;
  endtask

  task automatic run_op(input string req, input bit word, input bit sat,
                        input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    mac_go = 1; mac_form = word; sat_mode = sat; opnd_a = a; opnd_b = b;
    @(negedge clk);
    mac_go = 0;
    model(word, sat, a, b);
    check({req, " hi"}, acc_hi, m_hi);
    check({req, " lo"}, acc_lo, m_lo);
    check({req, " R9 done"}, {31'd0, mac_done}, 32'd1);
  endtask

  task automatic t_reset;
    check("R1 hi", acc_hi, 0);
    check("R1 lo", acc_lo, 0);
    check("R1 done", {31'd0, mac_done}, 0);
  endtask

  task automatic t_long_plain;
    set_acc(32'h0, 32'd5);
    run_op("R2 small", 0, 0, 32'hFFFF_FFFD, 32'd7);
    run_op("R2 big", 0, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    run_op("R2 negneg", 0, 0, 32'h8000_0000, 32'h8000_0000);
  endtask

  task automatic t_word_plain;
    set_acc(32'h0, 32'h0);
    run_op("R3 upper ignored", 1, 0, 32'hABCD_8000, 32'h1234_0002);
    run_op("R3 mixed", 1, 0, 32'hFFFF_7FFF, 32'h0000_FFFF);
  endtask

  task automatic t_long_sat;
    set_acc(32'h1234_5678, 32'h0);
    run_op("R4 positive", 0, 1, 32'd3, 32'd4);
    set_acc(32'h8000_1234, 32'h10);
    run_op("R4 negative", 0, 1, 32'd2, 32'd2);
  endtask

  task automatic t_word_sat;
    set_acc(32'h0, 32'h7FFF_FFF0);
    run_op("R5 over", 1, 1, 32'h100, 32'h100);
    check("R5 over marker", acc_hi, 32'd1);
    set_acc(32'hFFFF_FFFF, 32'h8000_0010);
    run_op("R5 under", 1, 1, 32'h100, 32'hFF00);
    check("R5 under clamp", acc_lo, 32'h8000_0000);
    set_acc(32'hFFFF_FFFF, 32'hFFFF_FFF0);
    run_op("R6 in range", 1, 1, 32'd3, 32'd9);
  endtask

  task automatic t_done_and_hold;
    @(negedge clk);
    check("R9 done one cycle", {31'd0, mac_done}, 0);
    repeat (3) @(negedge clk);
    check("R9 hold hi", acc_hi, m_hi);
    check("R9 hold lo", acc_lo, m_lo);
  endtask

  task automatic t_clear_load;
    set_acc(32'hDEAD_BEEF, 32'h0BAD_F00D);
    check("R8 hi", acc_hi, 32'hDEAD_BEEF);
    check("R8 lo", acc_lo, 32'h0BAD_F00D);
    @(negedge clk); ld_lo = 1; ld_data = 32'h5555_AAAA;
    @(negedge clk); ld_lo = 0;
    check("R8 lo only", acc_lo, 32'h5555_AAAA);
    check("R8 hi kept", acc_hi, 32'hDEAD_BEEF);
    @(negedge clk); acc_clr = 1; ld_hi = 1; ld_data = 32'h1;
    @(negedge clk); acc_clr = 0; ld_hi = 0;
    check("R7 hi", acc_hi, 0);
    check("R7 lo", acc_lo, 0);
  endtask

  task automatic t_collisions;
    set_acc(32'h0, 32'd100);
    @(negedge clk); mac_go = 1; mac_form = 0; sat_mode = 0;
    opnd_a = 32'd10; opnd_b = 32'd10; acc_clr = 1;
    @(negedge clk); mac_go = 0; acc_clr = 0;
    check("R10 clear+op hi", acc_hi, 0);
    check("R10 clear+op lo", acc_lo, 0);
    check("R10 clear+op done", {31'd0, mac_done}, 0);
    m_hi = 0; m_lo = 0;
    @(negedge clk); mac_go = 1; ld_hi = 1; ld_data = 32'h77;
    @(negedge clk); mac_go = 0; ld_hi = 0;
    m_hi = 32'h77;
    check("R10 load+op hi", acc_hi, 32'h77);
    check("R10 load+op lo", acc_lo, 32'h0);
    check("R10 load+op done", {31'd0, mac_done}, 0);
    run_op("R10 resume", 0, 0, 32'd10, 32'd10);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_long_plain();
        t_word_plain();
        t_long_sat();
        t_word_sat();
        t_done_and_hold();
        t_clear_load();
        t_collisions();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule